// File: doc/BRIEF.md
# Erased Sector Zero-Bit Screen

This block sits behind a sector ECC decoder that has reported a sector as uncorrectable. It decides whether that sector is in fact a freshly erased page with a few stuck bits. An erased page reads as all ones, and its stored check bytes read as all ones as well. Those check bytes do not match the code computed from all-ones data, so the decoder rejects the sector. The sector is fed to this block as a byte stream: first the data bytes, then the stored check bytes, one byte per cycle when `in_valid` is high, with `in_last` on the final check byte.

Two saturating counters count the zero bits, one for the data region and one for the check region. Each byte's zeros are the population count of its inverted value. When a counter has passed the correction strength, it ignores the rest of its region. In the cycle after the last byte, the block gives a one-cycle verdict. The sector counts as erased when the two counts together do not exceed the strength. An erased sector with at least one zero bit in its data raises a fill request, which tells a downstream stage to overwrite the data with 0xFF. The reported flip count is then the data zero count. A sector that is not erased is flagged uncorrectable. The block neither decodes the code nor writes the memory.

The sequencer has three states. DATA accepts data bytes. SPARE accepts check bytes. REPORT drives the verdict. The transitions are as follows:
- DATA→SPARE: the last data byte is accepted.
- SPARE→REPORT: a byte is accepted with `in_last` high.
- REPORT→DATA: unconditional, one cycle later. Both counters are cleared on this transition.

Top module: `erased_sector_check`

## Requirements
- R1: After reset, `verdict_valid`, `sector_erased`, `fill_req`, `uncorrectable` and `flip_count` are all 0.
- R2: The data zero count is the number of 0 bits over the first DATA_BYTES (512) accepted bytes, saturating at STRENGTH+1 (9).
- R3: The check zero count is the number of 0 bits over the next ECC_BYTES (13) accepted bytes, saturating at STRENGTH+1. A counter that has passed STRENGTH does not change for the rest of the sector.
- R4: During the verdict cycle, `sector_erased` is 1 exactly when data count plus check count is at most STRENGTH (8).
- R5: During the verdict cycle, `uncorrectable` is 1 exactly when the summed count exceeds STRENGTH. It is always the complement of `sector_erased`.
- R6: `fill_req` is 1 only in a verdict cycle where the sector is erased and the data zero count is nonzero.
- R7: `flip_count` equals the data zero count when the sector is erased, and 0 otherwise.
- R8: `verdict_valid` is high for exactly one cycle: the cycle after the byte carrying `in_last` is accepted. All verdict outputs are 0 outside that cycle.
- R9: Cycles with `in_valid` low add nothing to either count, whatever `in_byte` holds.
- R10: Each sector starts from zero counts. A sector that follows a saturated one is judged on its own bytes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `in_byte` carries a sector byte this cycle |
| in_byte | input | 8 | Sector byte: data region first, then check region |
| in_last | input | 1 | Marks the final check byte of the sector |
| verdict_valid | output | 1 | One-cycle strobe: the verdict outputs are valid |
| sector_erased | output | 1 | Sector is treated as erased |
| fill_req | output | 1 | Downstream stage must force the data region to 0xFF |
| flip_count | output | FLIP_W (4) | Number of data bits that the fill corrects |
| uncorrectable | output | 1 | Sector is not an erased page |

## Verification
The in-design assertions assume a well-formed stream. `in_last` arrives on exactly the final check byte, never earlier and never later. `in_valid` stays low during the verdict cycle. The bench builds every sector from a complete data region and a complete check region, and sets `in_last` only on byte DATA_BYTES+ECC_BYTES-1. It keeps `in_valid` low on the cycle after each last byte. Idle gaps with zero-valued junk on `in_byte` fall only inside a sector, so R9 is tested without breaking these assumptions.

// File: rtl/eraschk_pkg.sv
package eraschk_pkg;

    typedef enum logic [1:0] {
        ST_DATA   = 2'd0,
        ST_SPARE  = 2'd1,
        ST_REPORT = 2'd2
    } sect_state_e;

    function automatic int sat_width(input int strength);
        return $clog2(strength + 2);
    endfunction

endpackage

// File: rtl/eraschk_zero_pop.sv
module eraschk_zero_pop #(
    parameter int BYTE_W = 8,
    localparam int ZW = $clog2(BYTE_W + 1)
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic [ZW-1:0]     zeros_o
);

    always_comb begin
        zeros_o = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            zeros_o = zeros_o + ZW'(~byte_i[b]);
        end
    end

endmodule

// File: rtl/eraschk_sat_acc.sv
module eraschk_sat_acc #(
    parameter int LIMIT = 8,
    parameter int INW   = 4,
    parameter int CW    = 4,
    localparam int SW   = ((CW > INW) ? CW : INW) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           add_en,
    input  logic [INW-1:0] add_val,
    output logic [CW-1:0]  count_o
);

    logic [CW-1:0] count_q;
    logic [SW-1:0] sum_w;
    logic          open_w;

    assign open_w = (count_q <= CW'(LIMIT));
    assign sum_w  = SW'(count_q) + SW'(add_val);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count_q <= '0;
        end else if (add_en && open_w) begin
            if (sum_w > SW'(LIMIT + 1)) begin
                count_q <= CW'(LIMIT + 1);
            end else begin
                count_q <= sum_w[CW-1:0];
            end
        end
    end

    assign count_o = count_q;

    // R2 / R3: the count never exceeds the saturation ceiling
    assert_sat_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(LIMIT + 1));

    // R3: once past the limit, the count holds until cleared
    assert_hold_after_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q > CW'(LIMIT) && !clr) |=> $stable(count_q));

    // R9: no accepted byte, no change
    assert_idle_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !clr) |=> $stable(count_q));

endmodule

// File: rtl/eraschk_seq.sv
module eraschk_seq
    import eraschk_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int ECC_BYTES  = 13,
    localparam int MAXB      = (DATA_BYTES > ECC_BYTES) ? DATA_BYTES : ECC_BYTES,
    localparam int IW        = $clog2(MAXB)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_last,
    output sect_state_e state_o,
    output logic        data_take_o,
    output logic        ecc_take_o,
    output logic        clr_o
);

    sect_state_e state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_DATA: begin
                if (in_valid) begin
                    if (idx_q == IW'(DATA_BYTES - 1)) begin
                        state_d = ST_SPARE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_SPARE: begin
                if (in_valid) begin
                    if (in_last) begin
                        state_d = ST_REPORT;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_REPORT: begin
                state_d = ST_DATA;
                idx_d   = '0;
            end
            default: begin
                state_d = ST_DATA;
                idx_d   = '0;
            end
        endcase
    end

    always_comb begin
        data_take_o = 1'b0;
        ecc_take_o  = 1'b0;
        clr_o       = 1'b0;
        unique case (state_q)
            ST_DATA:   data_take_o = in_valid;
            ST_SPARE:  ecc_take_o  = in_valid;
            ST_REPORT: clr_o       = 1'b1;
            default:   clr_o       = 1'b1;
        endcase
    end

    assign state_o = state_q;

    // R8 (input rule): last marker only on the final check byte
    assert_last_placement_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |-> (state_q == ST_SPARE && idx_q == IW'(ECC_BYTES - 1)));

    // R8 (input rule): the final check byte always carries the marker
    assert_last_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state_q == ST_SPARE && idx_q == IW'(ECC_BYTES - 1)) |-> in_last);

    // R8 (input rule): no byte offered during the verdict cycle
    assert_report_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT) |-> !in_valid);

    // R10: report always returns to data intake
    assert_report_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT) |=> (state_q == ST_DATA));

endmodule

// File: rtl/erased_sector_check.sv
module erased_sector_check
    import eraschk_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int ECC_BYTES  = 13,
    parameter int STRENGTH   = 8,
    localparam int FLIP_W    = $clog2(STRENGTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    output logic              verdict_valid,
    output logic              sector_erased,
    output logic              fill_req,
    output logic [FLIP_W-1:0] flip_count,
    output logic              uncorrectable
);

    localparam int CW = sat_width(STRENGTH);
    localparam int ZW = $clog2(9);

    sect_state_e   state_w;
    logic          data_take_w, ecc_take_w, clr_w;
    logic [ZW-1:0] zeros_w;
    logic [CW-1:0] data_cnt_w, ecc_cnt_w;
    logic [CW:0]   total_w;

    eraschk_seq #(
        .DATA_BYTES (DATA_BYTES),
        .ECC_BYTES  (ECC_BYTES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .state_o     (state_w),
        .data_take_o (data_take_w),
        .ecc_take_o  (ecc_take_w),
        .clr_o       (clr_w)
    );

    eraschk_zero_pop #(.BYTE_W(8)) u_pop (
        .byte_i  (in_byte),
        .zeros_o (zeros_w)
    );

    eraschk_sat_acc #(.LIMIT(STRENGTH), .INW(ZW), .CW(CW)) u_data_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_w),
        .add_en  (data_take_w),
        .add_val (zeros_w),
        .count_o (data_cnt_w)
    );

    eraschk_sat_acc #(.LIMIT(STRENGTH), .INW(ZW), .CW(CW)) u_ecc_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_w),
        .add_en  (ecc_take_w),
        .add_val (zeros_w),
        .count_o (ecc_cnt_w)
    );

    assign total_w = (CW+1)'(data_cnt_w) + (CW+1)'(ecc_cnt_w);

    always_comb begin
        verdict_valid = 1'b0;
        sector_erased = 1'b0;
        fill_req      = 1'b0;
        flip_count    = '0;
        uncorrectable = 1'b0;
        unique case (state_w)
            ST_REPORT: begin
                verdict_valid = 1'b1;
                if (total_w <= (CW+1)'(STRENGTH)) begin
                    sector_erased = 1'b1;
                    flip_count    = FLIP_W'(data_cnt_w);
                    fill_req      = (data_cnt_w != '0);
                end else begin
                    uncorrectable = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    assert_quiet_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> !(sector_erased || fill_req || uncorrectable || flip_count != '0));

    assert_fill_erased_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (sector_erased && flip_count != '0));

    assert_complement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $onehot({sector_erased, uncorrectable}));

    assert_flip_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> flip_count <= FLIP_W'(STRENGTH));

endmodule

// File: tb/erased_sector_check_test.sv
`timescale 1ns/1ps
module erased_sector_check_test;

    localparam int NDATA = 512;
    localparam int NECC  = 13;
    localparam int STR   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_last = 1'b0;
    logic       verdict_valid, sector_erased, fill_req, uncorrectable;
    logic [3:0] flip_count;

    int n_checks = 0;
    int n_fails  = 0;
    bit running  = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int  m_pos = 0, m_dz = 0, m_ez = 0;
    bit  m_rep = 1'b0;

    always #4 clk = ~clk;

    erased_sector_check uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_byte       (in_byte),
        .in_last       (in_last),
        .verdict_valid (verdict_valid),
        .sector_erased (sector_erased),
        .fill_req      (fill_req),
        .flip_count    (flip_count),
        .uncorrectable (uncorrectable)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_dz = 0; m_ez = 0; m_rep = 1'b0;
        end else if (m_rep) begin
            m_rep = 1'b0; m_pos = 0; m_dz = 0; m_ez = 0;
        end else if (in_valid) begin
            int z;
            z = 8 - $countones(in_byte);
            if (m_pos < NDATA) begin
                if (m_dz <= STR) m_dz = (m_dz + z > STR + 1) ? STR + 1 : m_dz + z;
            end else begin
                if (m_ez <= STR) m_ez = (m_ez + z > STR + 1) ? STR + 1 : m_ez + z;
            end
            m_pos++;
            if (in_last) m_rep = 1'b1;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            bit er;
            er = m_rep && (m_dz + m_ez <= STR);
            check("R8", "verdict_valid", verdict_valid, m_rep);
            check("R4", "sector_erased", sector_erased, er);
            check("R5", "uncorrectable", uncorrectable, m_rep && !er);
            check("R6", "fill_req", fill_req, er && (m_dz != 0));
            check("R7", "flip_count", flip_count, er ? m_dz : 0);
        end
    end

    // build and stream one sector; zeros are packed from the low bits of leading bytes
    task automatic send_sector(input int dz_bits, input int ez_bits, input bit gaps,
                               input bit rnd, input string req,
                               input int e_erased, input int e_fill, input int e_flips);
        int rem_d, rem_e;
        rem_d = dz_bits;
        rem_e = ez_bits;
        for (int i = 0; i < NDATA + NECC; i++) begin
            int k;
            logic [7:0] b;
            if (gaps && (i % 64 == 5)) begin
                @(negedge clk);
                in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b0;
            end
            if (i < NDATA) begin
                k = (rem_d > 8) ? 8 : rem_d; rem_d -= k;
            end else begin
                k = (rem_e > 8) ? 8 : rem_e; rem_e -= k;
            end
            b = 8'hFF << k;
            if (rnd) b = 8'($urandom);
            @(negedge clk);
            in_valid = 1'b1; in_byte = b; in_last = (i == NDATA + NECC - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_byte = 8'h00;
        if (e_erased >= 0) begin
            check(req, "strobe at report", verdict_valid, 1);
            check(req, "erased verdict", sector_erased, e_erased);
            check(req, "fill verdict", fill_req, e_fill);
            check(req, "flip total", flip_count, e_flips);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "verdict_valid", verdict_valid, 0);
        check("R1", "outputs", {sector_erased, fill_req, uncorrectable}, 0);
        check("R1", "flip_count", flip_count, 0);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        send_sector(0, 0, 1'b0, 1'b0, "R4", 1, 0, 0);     // clean erased page
        send_sector(3, 2, 1'b0, 1'b0, "R6", 1, 1, 3);     // erased with stuck bits
        send_sector(0, 5, 1'b0, 1'b0, "R3", 1, 0, 0);     // zeros only in check bytes
        send_sector(4, 4, 1'b0, 1'b0, "R4", 1, 1, 4);     // exactly at the threshold
        send_sector(5, 4, 1'b0, 1'b0, "R5", 0, 0, 0);     // one over the threshold
        send_sector(8, 0, 1'b0, 1'b0, "R7", 1, 1, 8);     // all allowed zeros in data
        send_sector(0, 9, 1'b0, 1'b0, "R3", 0, 0, 0);     // check region alone too dirty
        send_sector(4000, 104, 1'b0, 1'b0, "R2", 0, 0, 0); // all-zero sector saturates
        send_sector(2, 1, 1'b0, 1'b0, "R10", 1, 1, 2);    // fresh counts after saturation
        send_sector(6, 1, 1'b1, 1'b0, "R9", 1, 1, 6);     // idle gaps with zero junk
        send_sector(0, 0, 1'b0, 1'b1, "R2", -1, 0, 0);    // random content, model only
        send_sector(1, 0, 1'b1, 1'b0, "R9", 1, 1, 1);
        repeat (3) @(negedge clk);
        check("R8", "strobe dropped", verdict_valid, 0);
        running = 1'b0;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule